// File: doc/BRIEF.md
# Paged Program Sequencer with Skip

This block steers instruction flow for a small 4-bit controller. It holds a 10-bit program counter made of a 4-bit page and a 6-bit in-page offset, and it presents that counter as the fetch address. Each cycle it decodes the fetched byte and reports whether the instruction in that slot really executes. It also reports whether the slot holds the operand byte of a two-word instruction. The accumulator, data memory and ports sit outside it. They read the same byte and act only while the execute-enable is high. The ALU feeds back a single skip request when a test or a carry asks for the next instruction to be dropped.

Control transfers come in three kinds. In-page jumps and calls replace only the offset. Long jumps and calls carry a 10-bit target split over two bytes. A return pops a two-level stack that keeps the two newest return addresses. Two kinds of instruction turn into no-operations without any ALU request. The first is the instruction that follows a skip request. The second is an immediate load, or a write of the memory-file select bit, that directly repeats the previous instruction's kind. This lets a program place alternative loads back to back and have only the first one take effect.

Top module: `psq_sequencer`

## Requirements
- R1: While reset is high, the fetch address is 000h and the operand-slot flag is 0. The first fetch after reset is from 000h.
- R2: When nothing else redirects the flow, the next fetch address adds 1 to the 6-bit offset modulo 64 and keeps the page, so offset 63 is followed by offset 0 of the same page.
- R3: An executed byte 10oooooo jumps in page: the next fetch keeps the page and uses oooooo as the offset.
- R4: An executed byte 11oooooo calls in page. It pushes the address of the call plus one (offset modulo 64) and continues at offset oooooo of the page. An executed 00011101 returns to the newest stacked address and moves the older entry up.
- R5: Bytes 010101tt and 010100tt are long jump and long call. Each is followed by an operand byte, and the operand slot is flagged with the operand-slot output. After the operand slot, the next fetch is the 10-bit target {tt, operand}. A long call pushes the operand address plus one.
- R6: A long call and an in-page call use the same stack, so a return after a long call resumes right after the operand byte.
- R7: With a stack of two levels, a third nested call drops the oldest return address. Returns past the bottom keep yielding the last remaining level-2 address.
- R8: A skip request seen in the cycle that completes an executed instruction makes the next instruction a no-operation: execute-enable is low and any branch in it has no effect. The following instruction executes again. A skip request in a squashed cycle is ignored.
- R9: An immediate accumulator load 0111nnnn that directly follows another fetch of 0111nnnn is squashed, and a chain of them leaves only the first executing.
- R10: An immediate index load 0100nnnn that directly follows another 0100nnnn is squashed. Loads of different kinds in a row both execute.
- R11: A select-bit write 00100100 or 00100101 that directly follows either of those two bytes is squashed.
- R12: A squashed two-word instruction uses both of its slots with execute-enable low, and its operand byte is never decoded as an instruction.
- R13: A repeat squash leaves the skip flag as it was. The history used for repeats is the previous first-byte fetch, whether or not it executed.
- R14: Byte 00001110 is a two-word compare. Its operand slot executes, and a skip request is honoured in the operand slot but not in the first slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| instr | input | 8 | Byte fetched from the current fetch address |
| skip_req | input | 1 | ALU request to drop the next instruction |
| fetch_addr | output | 10 | Program counter: page in the upper 4 bits, offset in the lower 6 |
| exec_en | output | 1 | The byte in this slot takes effect |
| second_byte | output | 1 | This slot holds the operand byte of a two-word instruction |

## Verification
The assertions check the local rules on every cycle. These are: that a squashed slot only advances the offset, that an in-page jump lands on its offset, and that a two-word opcode is always followed by exactly one operand slot with the same execute-enable. They also check that back-to-back repeats of the three instruction kinds never execute, and that a honoured skip request kills the following slot. The bench's scenarios show the rest. That covers stack contents after overflow and underflow, where long targets land across all 1024 addresses, and the page wrap at offset 63. It also covers the interplay of the skip flag with repeat history, and the cases where the operand byte resembles an opcode.

// File: rtl/psq_pkg.sv
package psq_pkg;

  // Instruction kinds that the back-to-back repeat rule applies to
  typedef enum logic [1:0] {
    RPT_NONE = 2'd0,
    RPT_ACC  = 2'd1,
    RPT_IDX  = 2'd2,
    RPT_SEL  = 2'd3
  } rpt_cls_t;

  // Flow-control classes of a first byte
  typedef enum logic [2:0] {
    OP_PLAIN    = 3'd0,
    OP_JMP_PAGE = 3'd1,
    OP_CAL_PAGE = 3'd2,
    OP_RETURN   = 3'd3,
    OP_JMP_LONG = 3'd4,
    OP_CAL_LONG = 3'd5,
    OP_CMP_TWO  = 3'd6
  } op_kind_t;

  // Sources for the next program counter
  typedef enum logic [1:0] {
    NXT_INC   = 2'd0,
    NXT_PAGE  = 2'd1,
    NXT_LONG  = 2'd2,
    NXT_STACK = 2'd3
  } nxt_sel_t;

  typedef struct packed {
    op_kind_t kind;
    rpt_cls_t cls;
    logic     two_word;
  } op_info_t;

endpackage

// File: rtl/psq_decode.sv
module psq_decode
  import psq_pkg::*;
(
  input  logic [7:0] opcode,
  output op_info_t   info
);

  always_comb begin
    info.kind     = OP_PLAIN;
    info.cls      = RPT_NONE;
    info.two_word = 1'b0;
    casez (opcode)
      8'b10??????: info.kind = OP_JMP_PAGE;
      8'b11??????: info.kind = OP_CAL_PAGE;
      8'b010101??: begin
        info.kind     = OP_JMP_LONG;
        info.two_word = 1'b1;
      end
      8'b010100??: begin
        info.kind     = OP_CAL_LONG;
        info.two_word = 1'b1;
      end
      8'b00001110: begin
        info.kind     = OP_CMP_TWO;
        info.two_word = 1'b1;
      end
      8'b00011101: info.kind = OP_RETURN;
      8'b0111????: info.cls  = RPT_ACC;
      8'b0100????: info.cls  = RPT_IDX;
      8'b0010010?: info.cls  = RPT_SEL;
      default: ;
    endcase
  end

endmodule

// File: rtl/psq_retstack.sv
module psq_retstack #(
  parameter int W     = 10,
  parameter int DEPTH = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         push,
  input  logic         pop,
  input  logic [W-1:0] din,
  output logic [W-1:0] top
);

  logic [W-1:0] lvl [DEPTH];

  // Push shifts toward the bottom and loses the oldest entry;
  // pop shifts toward the top and the bottom level keeps its value.
  for (genvar i = 0; i < DEPTH; i++) begin : g_lvl
    if (i == 0 && DEPTH == 1) begin : g_only
      always_ff @(posedge clk) begin
        if (rst)       lvl[i] <= '0;
        else if (push) lvl[i] <= din;
      end
    end else if (i == 0) begin : g_top
      always_ff @(posedge clk) begin
        if (rst)       lvl[i] <= '0;
        else if (push) lvl[i] <= din;
        else if (pop)  lvl[i] <= lvl[i+1];
      end
    end else if (i == DEPTH - 1) begin : g_bot
      always_ff @(posedge clk) begin
        if (rst)       lvl[i] <= '0;
        else if (push) lvl[i] <= lvl[i-1];
      end
    end else begin : g_mid
      always_ff @(posedge clk) begin
        if (rst)       lvl[i] <= '0;
        else if (push) lvl[i] <= lvl[i-1];
        else if (pop)  lvl[i] <= lvl[i+1];
      end
    end
  end

  assign top = lvl[0];

endmodule

// File: rtl/psq_addr_gen.sv
module psq_addr_gen
  import psq_pkg::*;
#(
  parameter int PAGE_W = 4,
  parameter int OFF_W  = 6
) (
  input  logic [PAGE_W+OFF_W-1:0] pc,
  input  nxt_sel_t                sel,
  input  logic [OFF_W-1:0]        page_off,
  input  logic [PAGE_W+OFF_W-1:0] long_tgt,
  input  logic [PAGE_W+OFF_W-1:0] stack_top,
  output logic [PAGE_W+OFF_W-1:0] pc_inc,
  output logic [PAGE_W+OFF_W-1:0] pc_nxt
);

  localparam int ADDR_W = PAGE_W + OFF_W;

  logic [PAGE_W-1:0] page;
  logic [OFF_W-1:0]  off;

  assign page   = pc[ADDR_W-1:OFF_W];
  assign off    = pc[OFF_W-1:0];
  // Offset wraps inside the page; the page field never carries
  assign pc_inc = {page, off + OFF_W'(1)};

  always_comb begin
    unique case (sel)
      NXT_PAGE:  pc_nxt = {page, page_off};
      NXT_LONG:  pc_nxt = long_tgt;
      NXT_STACK: pc_nxt = stack_top;
      default:   pc_nxt = pc_inc;
    endcase
  end

endmodule

// File: rtl/psq_sequencer.sv
module psq_sequencer
  import psq_pkg::*;
#(
  parameter int PAGE_W      = 4,
  parameter int OFF_W       = 6,
  parameter int STACK_DEPTH = 2
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [7:0]              instr,
  input  logic                    skip_req,
  output logic [PAGE_W+OFF_W-1:0] fetch_addr,
  output logic                    exec_en,
  output logic                    second_byte
);

  localparam int ADDR_W    = PAGE_W + OFF_W;
  localparam int LONG_HI_W = ADDR_W - 8;

  op_info_t              info;
  logic [ADDR_W-1:0]     pc_q, pc_inc, pc_nxt, stack_top, long_tgt;
  logic                  phase_q, skip_q, pend_kill_q;
  op_kind_t              pend_kind_q;
  logic [LONG_HI_W-1:0]  pend_hi_q;
  rpt_cls_t              hist_q;
  logic                  rep_hit, kill_first, done, push, pop;
  nxt_sel_t              sel;

  psq_decode u_dec (
    .opcode (instr),
    .info   (info)
  );

  // Repeat check: same repeat kind as the previous first-byte fetch
  assign rep_hit    = !phase_q && (info.cls != RPT_NONE) && (info.cls == hist_q);
  assign kill_first = skip_q || rep_hit;
  assign exec_en    = phase_q ? !pend_kill_q : !kill_first;
  assign done       = phase_q || !info.two_word;
  assign long_tgt   = {pend_hi_q, instr};

  always_comb begin
    sel  = NXT_INC;
    push = 1'b0;
    pop  = 1'b0;
    if (phase_q) begin
      if (!pend_kill_q && pend_kind_q == OP_JMP_LONG) begin
        sel = NXT_LONG;
      end else if (!pend_kill_q && pend_kind_q == OP_CAL_LONG) begin
        sel  = NXT_LONG;
        push = 1'b1;
      end
    end else if (!kill_first) begin
      unique case (info.kind)
        OP_JMP_PAGE: sel = NXT_PAGE;
        OP_CAL_PAGE: begin
          sel  = NXT_PAGE;
          push = 1'b1;
        end
        OP_RETURN: begin
          sel = NXT_STACK;
          pop = 1'b1;
        end
        default: sel = NXT_INC;
      endcase
    end
  end

  psq_addr_gen #(
    .PAGE_W (PAGE_W),
    .OFF_W  (OFF_W)
  ) u_agen (
    .pc        (pc_q),
    .sel       (sel),
    .page_off  (instr[OFF_W-1:0]),
    .long_tgt  (long_tgt),
    .stack_top (stack_top),
    .pc_inc    (pc_inc),
    .pc_nxt    (pc_nxt)
  );

  psq_retstack #(
    .W     (ADDR_W),
    .DEPTH (STACK_DEPTH)
  ) u_stk (
    .clk  (clk),
    .rst  (rst),
    .push (push),
    .pop  (pop),
    .din  (pc_inc),
    .top  (stack_top)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      pc_q        <= '0;
      phase_q     <= 1'b0;
      skip_q      <= 1'b0;
      hist_q      <= RPT_NONE;
      pend_kill_q <= 1'b0;
      pend_kind_q <= OP_PLAIN;
      pend_hi_q   <= '0;
    end else begin
      pc_q    <= pc_nxt;
      phase_q <= !phase_q && info.two_word;
      // A set flag is consumed by the first slot it kills; a request is
      // taken only when an executed instruction completes
      if (!phase_q && skip_q)  skip_q <= 1'b0;
      else if (done && exec_en) skip_q <= skip_req;
      if (!phase_q) begin
        hist_q      <= info.cls;
        pend_kill_q <= kill_first;
        pend_kind_q <= info.kind;
        pend_hi_q   <= instr[LONG_HI_W-1:0];
      end
    end
  end

  assign fetch_addr  = pc_q;
  assign second_byte = phase_q;

endmodule

// File: rtl/psq_sequencer_chk.sv
module psq_sequencer_chk #(
  parameter int PAGE_W = 4,
  parameter int OFF_W  = 6
) (
  input logic                    clk,
  input logic                    rst,
  input logic [7:0]              instr,
  input logic                    skip_req,
  input logic [PAGE_W+OFF_W-1:0] fetch_addr,
  input logic                    exec_en,
  input logic                    second_byte
);

  localparam int ADDR_W = PAGE_W + OFF_W;

  logic rst_d = 1'b0;
  logic two_op;

  assign two_op = (instr[7:2] == 6'b010101) || (instr[7:2] == 6'b010100) || (instr == 8'h0E);

  always_ff @(posedge clk) rst_d <= rst;

  // R1: one edge after reset the counter is at address zero
  always_ff @(posedge clk) begin
    if (rst_d) begin
      a_r1_reset_addr: assert (fetch_addr == '0 && !second_byte)
        else $error("reset state wrong");
    end
  end

  a_r2_squash_advances: assert property (@(posedge clk) disable iff (rst)
    !exec_en |=> fetch_addr == {$past(fetch_addr[ADDR_W-1:OFF_W]),
                                $past(fetch_addr[OFF_W-1:0]) + OFF_W'(1)});

  a_r3_page_jump: assert property (@(posedge clk) disable iff (rst)
    (!second_byte && exec_en && instr[7:6] == 2'b10) |=>
      fetch_addr == {$past(fetch_addr[ADDR_W-1:OFF_W]), $past(instr[OFF_W-1:0])});

  a_r5_operand_slot: assert property (@(posedge clk) disable iff (rst)
    (!second_byte && two_op) |=> second_byte);

  a_r12_one_operand: assert property (@(posedge clk) disable iff (rst)
    second_byte |=> !second_byte);

  a_r12_operand_follows: assert property (@(posedge clk) disable iff (rst)
    second_byte |-> exec_en == $past(exec_en));

  a_r8_skip_kills: assert property (@(posedge clk) disable iff (rst)
    ((second_byte || !two_op) && exec_en && skip_req) |=> !exec_en);

  a_r9_acc_repeat: assert property (@(posedge clk) disable iff (rst)
    (!second_byte && instr[7:4] == 4'h7) |=>
      ((!second_byte && instr[7:4] == 4'h7) -> !exec_en));

  a_r10_idx_repeat: assert property (@(posedge clk) disable iff (rst)
    (!second_byte && instr[7:4] == 4'h4) |=>
      ((!second_byte && instr[7:4] == 4'h4) -> !exec_en));

  a_r11_sel_repeat: assert property (@(posedge clk) disable iff (rst)
    (!second_byte && instr[7:1] == 7'b0010010) |=>
      ((!second_byte && instr[7:1] == 7'b0010010) -> !exec_en));

endmodule

bind psq_sequencer psq_sequencer_chk #(
  .PAGE_W (PAGE_W),
  .OFF_W  (OFF_W)
) u_chk (
  .clk         (clk),
  .rst         (rst),
  .instr       (instr),
  .skip_req    (skip_req),
  .fetch_addr  (fetch_addr),
  .exec_en     (exec_en),
  .second_byte (second_byte)
);

// File: tb/sim_psq_sequencer.sv
`timescale 1ns/1ps
module sim_psq_sequencer;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] instr;
  logic       skip_req = 1'b0;
  logic [9:0] fetch_addr;
  logic       exec_en, second_byte;
  logic [7:0] rom [1024];
  int         n_chk = 0;
  int         n_fail = 0;

  always #2.5 clk = ~clk;

  assign instr = rom[fetch_addr];

  psq_sequencer u0 (
    .clk         (clk),
    .rst         (rst),
    .instr       (instr),
    .skip_req    (skip_req),
    .fetch_addr  (fetch_addr),
    .exec_en     (exec_en),
    .second_byte (second_byte)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic clear_rom();
    for (int i = 0; i < 1024; i++) rom[i] = 8'h00;
  endtask

  task automatic do_reset();
    rst = 1'b1;
    skip_req = 1'b0;
    @(posedge clk);
    @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
  endtask

  // Check the current slot, drive the skip request for it, advance one cycle
  task automatic cyc(input int ea, input bit ee, input bit es, input bit sr, input string tag);
    chk({tag, " addr"}, fetch_addr, ea);
    chk({tag, " exec"}, exec_en, ee);
    chk({tag, " slot"}, second_byte, es);
    skip_req = sr;
    @(posedge clk);
    @(negedge clk);
    skip_req = 1'b0;
  endtask

  task automatic report();
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    report();
  end

  initial begin
    clear_rom();
    do_reset();
    chk("R1 first fetch", fetch_addr, 0);
    chk("R1 slot flag", second_byte, 0);

    // R2 + R5: long jump to page 3 offset 62, then wrap inside page 3
    clear_rom();
    rom[0] = 8'h54; rom[1] = 8'hFE;
    do_reset();
    cyc(0, 1, 0, 0, "R5 first");
    cyc(1, 1, 1, 0, "R5 operand");
    cyc(10'h0FE, 1, 0, 0, "R5 target");
    cyc(10'h0FF, 1, 0, 0, "R2 offset 63");
    cyc(10'h0C0, 1, 0, 0, "R2 wrap in page");

    // R5 sweep: every long target
    for (int t = 0; t < 1024; t++) begin
      clear_rom();
      rom[0] = 8'h54 | 8'(t >> 8);
      rom[1] = 8'(t & 255);
      do_reset();
      @(posedge clk); @(negedge clk);
      chk("R5 sweep slot", second_byte, 1);
      @(posedge clk); @(negedge clk);
      chk("R5 sweep target", fetch_addr, t);
    end

    // R3 sweep: every in-page offset from page 5
    for (int o = 0; o < 64; o++) begin
      clear_rom();
      rom[0] = 8'h55; rom[1] = 8'h4A;
      rom[330] = 8'h80 | 8'(o);
      do_reset();
      repeat (3) begin @(posedge clk); @(negedge clk); end
      chk("R3 sweep", fetch_addr, 320 + o);
    end

    // R4, R6, R7: nested calls, overflow, returns, underflow
    clear_rom();
    rom[0] = 8'hD0;
    rom[10'h010] = 8'h52; rom[10'h011] = 8'h00;
    rom[10'h200] = 8'hE0;
    rom[10'h220] = 8'h1D;
    rom[10'h201] = 8'h1D;
    rom[10'h012] = 8'h1D;
    do_reset();
    cyc(0, 1, 0, 0, "R4 page call");
    cyc(10'h010, 1, 0, 0, "R6 long call");
    cyc(10'h011, 1, 1, 0, "R6 operand");
    cyc(10'h200, 1, 0, 0, "R4 third call");
    cyc(10'h220, 1, 0, 0, "R4 return");
    cyc(10'h201, 1, 0, 0, "R7 return newest");
    cyc(10'h012, 1, 0, 0, "R6 return after long call");
    cyc(10'h012, 1, 0, 0, "R7 underflow repeats");
    chk("R7 underflow again", fetch_addr, 10'h012);
    rst = 1'b1;
    @(posedge clk); @(negedge clk);
    chk("R1 reset addr", fetch_addr, 0);
    chk("R1 reset slot", second_byte, 0);

    // R8: skip request squashes a jump; request in a squashed slot ignored
    clear_rom();
    rom[1] = 8'hB0;
    do_reset();
    cyc(0, 1, 0, 1, "R8 request");
    cyc(1, 0, 0, 1, "R8 squashed jump");
    cyc(2, 1, 0, 0, "R8 flag cleared");

    // R9 + R10: immediate load chains
    clear_rom();
    rom[0] = 8'h75; rom[1] = 8'h73; rom[2] = 8'h71;
    rom[3] = 8'h48; rom[4] = 8'h44;
    do_reset();
    cyc(0, 1, 0, 0, "R9 first load");
    cyc(1, 0, 0, 0, "R9 repeat");
    cyc(2, 0, 0, 0, "R9 chain");
    cyc(3, 1, 0, 0, "R10 other kind runs");
    cyc(4, 0, 0, 0, "R10 repeat");
    cyc(5, 1, 0, 0, "R10 after chain");

    // R11: select-bit writes
    clear_rom();
    rom[0] = 8'h25; rom[1] = 8'h24; rom[2] = 8'h25; rom[4] = 8'h24;
    do_reset();
    cyc(0, 1, 0, 0, "R11 first");
    cyc(1, 0, 0, 0, "R11 opposite write");
    cyc(2, 0, 0, 0, "R11 chain");
    cyc(3, 1, 0, 0, "R11 break");
    cyc(4, 1, 0, 0, "R11 runs after break");

    // R12: squashed long jump whose operand looks like a load
    clear_rom();
    rom[1] = 8'h55; rom[2] = 8'h70; rom[3] = 8'h72;
    do_reset();
    cyc(0, 1, 0, 1, "R12 request");
    cyc(1, 0, 0, 0, "R12 first slot");
    cyc(2, 0, 1, 0, "R12 operand slot");
    cyc(3, 1, 0, 0, "R12 operand not decoded");
    cyc(4, 1, 0, 0, "R12 continues");

    // R13: history includes squashed fetches; repeat leaves flag alone
    clear_rom();
    rom[1] = 8'h71; rom[2] = 8'h72; rom[4] = 8'h71; rom[5] = 8'h72;
    do_reset();
    cyc(0, 1, 0, 1, "R13 request");
    cyc(1, 0, 0, 0, "R13 flag squash");
    cyc(2, 0, 0, 0, "R13 repeat after squash");
    cyc(3, 1, 0, 0, "R13 flag clear");
    cyc(4, 1, 0, 0, "R13 load");
    cyc(5, 0, 0, 1, "R13 repeat ignores request");
    cyc(6, 1, 0, 0, "R13 flag unchanged");

    // R14: two-word compare
    clear_rom();
    rom[0] = 8'h0E; rom[1] = 8'h75; rom[4] = 8'h0E;
    do_reset();
    cyc(0, 1, 0, 0, "R14 first");
    cyc(1, 1, 1, 1, "R14 operand request");
    cyc(2, 0, 0, 0, "R14 skipped");
    cyc(3, 1, 0, 0, "R14 resumes");
    cyc(4, 1, 0, 1, "R14 first slot request");
    cyc(5, 1, 1, 0, "R14 operand");
    cyc(6, 1, 0, 0, "R14 first slot ignored");

    report();
  end

endmodule